// File: doc/BRIEF.md
# Sequential Radix-2 Recoded Signed Multiplier

This block multiplies two W-bit two's-complement operands, one step per clock cycle. It pairs the low bit of the multiplier with a trailing flip-flop below it. At the lower edge of a run of ones in the multiplier it subtracts the multiplicand from the running partial product. At the upper edge of such a run it adds the multiplicand. Inside a run, or inside a run of zeros, the partial product is left alone. After every such step, the concatenation of partial product, multiplier register and trailing bit shifts right by one arithmetically. Negative operands need no sign fix-up before or after.

Operands enter over a valid/ready handshake. The block takes one pair when `in_valid` and `in_ready` are both high on a rising edge. It holds `in_ready` low from then until the result has been taken, so `in_valid` may stay asserted meanwhile without effect. The 2W-bit product is then offered with `out_valid`. It stays frozen for as long as the consumer keeps `out_ready` low. It is released on the edge where both are high.

Top module: `booth_mul`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` is 1 only while no operation is in flight. Operands presented while `in_ready` is 0 are ignored: the result of the pair in flight is unaffected, and no second operation starts. `in_ready` and `out_valid` are never high together.
- R3: `out_prod` equals the signed product of `in_mcand` and `in_mplier`, both read as W-bit two's complement. The product is a 2W-bit two's-complement value, with the high half in bits 2W-1..W.
- R4: `out_valid` first goes high exactly W rising edges after the edge that accepted the operands.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_prod` does not change.
- R6: On the cycle after an edge where `out_valid` and `out_ready` are both 1, `out_valid` is 0 and `in_ready` is 1.
- R7: The most negative value times itself gives the positive product 2^(2W-2). For W=8 this is 0x4000.
- R8: A zero operand on either side gives an all-zero product. A multiplier of all ones (-1) gives the negated multiplicand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block can accept an operand pair |
| in_mcand | input | W | Multiplicand, two's complement |
| in_mplier | input | W | Multiplier, two's complement |
| out_valid | output | 1 | Product is offered |
| out_ready | input | 1 | Consumer takes the product |
| out_prod | output | 2W | Signed product |

## Verification
Two of the block's functions can fall in the same cycle: the final recoding step, which adds or subtracts the multiplicand, and loop termination. For example, a multiplier whose top bit differs from the bit below it forces an add or subtract on the last step, just as the counter expires. The vector table includes such multipliers, for example 0x80 and 0x7F. Each product is judged against a signed reference computed in the bench, and the latency is counted from the accepting edge. A second overlap lies at the output edge, where a new operand pair is already waiting. Holding `in_valid` high through a whole operation with other operands provokes it. The bench then confirms that the first product is intact and that no extra result appears.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} state_t;
  typedef enum logic [1:0] {OP_KEEP, OP_ADD, OP_SUB} op_t;
endpackage

// File: rtl/booth_decode.sv
module booth_decode
  import booth_pkg::*;
(
  input  logic low_bit,
  input  logic trail_bit,
  output op_t  op
);
  always_comb begin
    case ({low_bit, trail_bit})
      2'b10:   op = OP_SUB;   // lower edge of a run of ones
      2'b01:   op = OP_ADD;   // upper edge of a run of ones
      default: op = OP_KEEP;  // inside a run
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic [AW-1:0] acc,
  input  logic [AW-1:0] mcand,
  input  op_t           op,
  output logic [AW-1:0] res
);
  always_comb begin
    case (op)
      OP_ADD:  res = acc + mcand;
      OP_SUB:  res = acc - mcand;
      default: res = acc;
    endcase
  end
endmodule

// File: rtl/booth_counter.sv
module booth_counter #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic last
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] START = CW'(W);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= START;
    else if (step) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CW'(1));
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_mcand,
  input  logic [W-1:0]   in_mplier,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_prod
);
  // One guard bit on the partial product so that subtracting the most
  // negative multiplicand cannot wrap.
  localparam int AW = W + 1;

  state_t          state;
  logic [AW-1:0]   acc;
  logic [AW-1:0]   mcand_q;
  logic [W-1:0]    mplier_q;
  logic            trail_q;
  op_t             op;
  logic [AW-1:0]   sum;
  logic            accept;
  logic            running;
  logic            last_step;

  assign accept  = in_valid && (state == ST_IDLE);
  assign running = (state == ST_RUN);

  booth_decode u_dec (
    .low_bit   (mplier_q[0]),
    .trail_bit (trail_q),
    .op        (op)
  );

  booth_addsub #(.AW(AW)) u_alu (
    .acc   (acc),
    .mcand (mcand_q),
    .op    (op),
    .res   (sum)
  );

  booth_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .step  (running),
    .last  (last_step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      acc      <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      trail_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            acc      <= '0;
            trail_q  <= 1'b0;
            mplier_q <= in_mplier;
            mcand_q  <= {in_mcand[W-1], in_mcand};
            state    <= ST_RUN;
          end
        end
        ST_RUN: begin
          // arithmetic shift right of {partial, multiplier, trailing bit}
          {acc, mplier_q, trail_q} <= {sum[AW-1], sum, mplier_q};
          if (last_step) state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);
  assign out_prod  = {acc[W-1:0], mplier_q};
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*W-1:0] out_prod
);
  localparam int LW = $clog2(W + 2) + 1;

  logic          busy;
  logic [LW-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      lat  <= '0;
    end else if (in_valid && in_ready) begin
      busy <= 1'b1;
      lat  <= LW'(1);
    end else if (out_valid) begin
      busy <= 1'b0;
    end else if (busy) begin
      lat <= lat + 1'b1;
    end
  end

  // R2
  ready_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, out_valid}));

  // R4
  lat_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_valid && lat < LW'(W)) |=> !out_valid);

  // R4
  lat_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_valid && lat == LW'(W)) |=> out_valid);

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));
endmodule

bind booth_mul booth_mul_chk #(.W(W)) u_booth_mul_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_prod  (out_prod)
);

// File: tb/booth_mul_tb_top.sv
module booth_mul_tb_top;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 100000;
  localparam int NVEC = 12;
  // {multiplicand, multiplier}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0305, 16'hFD05, 16'h03FB, 16'hFDFB, 16'h8080, 16'h807F,
    16'h7F80, 16'h7F7F, 16'h0000, 16'h5AFF, 16'h00AA, 16'h5555
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [W-1:0]   in_mcand = '0;
  logic [W-1:0]   in_mplier = '0;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic [2*W-1:0] out_prod;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_mul #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mcand(in_mcand), .in_mplier(in_mplier), .out_valid(out_valid),
    .out_ready(out_ready), .out_prod(out_prod)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_prod(input logic [7:0] a, input logic [7:0] b);
    int p;
    p = int'($signed(a)) * int'($signed(b));
    return p[15:0];
  endfunction

  // Start an operation, wait for the result; optionally keep offering other operands.
  task automatic run(input logic [7:0] a, input logic [7:0] b, input bit keep_valid,
                     input int stall, output logic [15:0] prod, output int lat);
    @(negedge clk);
    in_valid = 1'b1; in_mcand = a; in_mplier = b;
    chk(in_ready == 1'b1, "R2 ready idle", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    if (keep_valid) begin
      in_mcand = ~a; in_mplier = b + 8'd3;
    end else in_valid = 1'b0;
    lat = 0;
    while (!out_valid) begin
      if (keep_valid) chk(in_ready == 1'b0, "R2 busy not ready", int'(in_ready), 0);
      @(posedge clk); @(negedge clk); lat++;
    end
    prod = out_prod;
    for (int i = 0; i < stall; i++) begin
      @(posedge clk); @(negedge clk);
      chk(out_valid == 1'b1, "R5 valid held", int'(out_valid), 1);
      chk(out_prod == prod, "R5 product held", int'(out_prod), int'(prod));
    end
    if (keep_valid) in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R6 valid drops", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R6 ready returns", int'(in_ready), 1);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R4 actual=hang expected=result");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] p;
    int lat;
    logic [7:0] a, b;
    logic [15:0] lfsr;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);

    // table of vectors, R3 / R7 / R8 / R4
    for (int v = 0; v < NVEC; v++) begin
      a = VEC[v][15:8]; b = VEC[v][7:0];
      run(a, b, 1'b0, 0, p, lat);
      chk(p == ref_prod(a, b), "R3 product", int'(p), int'(ref_prod(a, b)));
      chk(lat == W, "R4 latency", lat, W);
    end

    // R7 most negative squared
    run(8'h80, 8'h80, 1'b0, 0, p, lat);
    chk(p == 16'h4000, "R7 min times min", int'(p), 16'h4000);

    // R8 zero and all-ones multiplier
    run(8'h00, 8'h93, 1'b0, 0, p, lat);
    chk(p == 16'h0000, "R8 zero multiplicand", int'(p), 0);
    run(8'h93, 8'h00, 1'b0, 0, p, lat);
    chk(p == 16'h0000, "R8 zero multiplier", int'(p), 0);
    run(8'h93, 8'hFF, 1'b0, 0, p, lat);
    chk(p == 16'h006D, "R8 minus one multiplier", int'(p), 16'h006D);

    // R2 operands offered while busy are ignored
    run(8'h03, 8'h05, 1'b1, 0, p, lat);
    chk(p == 16'h000F, "R2 busy operands ignored", int'(p), 16'h000F);
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      chk(out_valid == 1'b0, "R2 no extra result", int'(out_valid), 0);
    end

    // R5 back-pressure
    run(8'hC7, 8'h6B, 1'b0, 5, p, lat);
    chk(p == ref_prod(8'hC7, 8'h6B), "R5 product after stall", int'(p),
        int'(ref_prod(8'hC7, 8'h6B)));

    // pseudo-random sweep, R3
    lfsr = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr[15:8]; b = lfsr[7:0] ^ lfsr[12:5];
      run(a, b, 1'b0, 0, p, lat);
      chk(p == ref_prod(a, b), "R3 sweep product", int'(p), int'(ref_prod(a, b)));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule